// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block moves up to N messages at once from N input ports to N output ports through an Omega network. The network has log2 N stages. Each stage has N/2 two-by-two switches, and a fixed perfect-shuffle wiring pattern feeds every stage. Each input lane carries four fields: a valid bit, a broadcast request bit, a destination port index and a data word. Every switch sets itself from the tags on its two inputs. Setting a switch needs no central controller.

Some input patterns cannot be routed without two messages needing the same internal link. When that happens, the switch lets the message on its upper input through and drops the message on its lower input. The block then raises a blocked flag against the input port that sent the dropped message. The block also reports the setting that each switch chose. Each delivered word carries the index of its source port, so the receiver can tell where it came from. All outputs are registered, so a set of messages presented in one cycle appears at the outputs in the next cycle.

Top module: `omega_net`

## Requirements
- R1: The outputs (`out_valid_o`, `out_data_o`, `out_src_o`, `blocked_o`, `mode_o`) reflect the inputs sampled at the previous rising clock edge. Asserting `rst_ni` low clears all of these outputs at once, without waiting for a clock edge.
- R2: A unicast message that is not blocked appears on the output port whose index equals its destination. It carries its data word, and the index of its input port in `out_src_o[j*LOG_N +: LOG_N]`. An output port that receives nothing shows valid 0, data 0 and source 0.
- R3: Routing follows these rules. Before each stage, line i moves to line rotate-left-by-one(i) within LOG_N bits. Switch m joins line 2m (its upper input and output) and line 2m+1 (its lower input and output). At stage k, counted from 0 at the input side, destination bit LOG_N-1-k selects the output: 0 selects upper and 1 selects lower.
- R4: `mode_o[2*(k*N/2+m) +: 2]` reports the setting of switch m in stage k. The codes are: 00 straight, 01 crossed, 10 upper input copied to both outputs, 11 lower input copied to both outputs. A switch with no valid input reports 00.
- R5: When both inputs of a switch are valid and need the same output, the upper input wins. The lower message is delivered nowhere, and `blocked_o[s]` is set, where s is that message's input port.
- R6: A valid upper input with its broadcast bit set is copied to both outputs of its switch. A valid lower input at that switch is then blocked. The broadcast bit travels with the message through every stage, so a lone broadcast message reaches all N outputs.
- R7: A lower input is copied to both outputs only when it requests broadcast and the upper input of its switch is idle. If the upper input is valid, the lower message is routed by its destination bit as if it were unicast at that switch.
- R8: An input whose valid bit is 0 has no effect, whatever its data, destination or broadcast bits hold. It reaches no output, and its blocked flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | Per-input message valid |
| in_bcast_i | input | N_PORTS | Per-input broadcast request |
| in_dst_i | input | N_PORTS*LOG_N | Destination port index, input i at [i*LOG_N +: LOG_N] |
| in_data_i | input | N_PORTS*DATA_W | Data word, input i at [i*DATA_W +: DATA_W] |
| out_valid_o | output | N_PORTS | Per-output delivery valid |
| out_data_o | output | N_PORTS*DATA_W | Delivered data word per output |
| out_src_o | output | N_PORTS*LOG_N | Source input index per output |
| blocked_o | output | N_PORTS | Per-input blocked flag |
| mode_o | output | LOG_N*N_PORTS | Two-bit setting of every switch |

## Verification
The assertions assume two things about the inputs. First, inputs change only away from the rising edge. Second, the count of delivered plus blocked messages only has to match the count of valid inputs when no input requested broadcast in that cycle. A warm-up flag keeps every history-based property quiet until the first clock after reset. The stimulus changes inputs only on falling edges. It mixes sparse random traffic, full conflict-free-or-not permutations and rare broadcast requests. Directed cases force the upper-wins conflict, both broadcast rules and idle inputs that carry stray tags.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic [1:0] {
    MODE_STRAIGHT = 2'b00,
    MODE_CROSS    = 2'b01,
    MODE_UP_BC    = 2'b10,
    MODE_LO_BC    = 2'b11
  } sw_mode_e;

  // perfect shuffle: rotate line index left by one within lg bits
  function automatic int shuffle_idx(input int idx, input int lg);
    int msk;
    msk = (1 << lg) - 1;
    return ((idx << 1) | (idx >> (lg - 1))) & msk;
  endfunction

endpackage

// File: rtl/omega_shuffle.sv
module omega_shuffle #(
  parameter int N_PORTS = 8,
  parameter int LANE_W  = 16
) (
  input  logic [N_PORTS*LANE_W-1:0] lanes_i,
  output logic [N_PORTS*LANE_W-1:0] lanes_o
);
  localparam int LOG_N = $clog2(N_PORTS);

  for (genvar i = 0; i < N_PORTS; i++) begin : g_wire
    localparam int DST = omega_pkg::shuffle_idx(i, LOG_N);
    assign lanes_o[DST*LANE_W +: LANE_W] = lanes_i[i*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int LOG_N   = 3,
  parameter int DATA_W  = 8,
  parameter int TAG_BIT = 0,
  localparam int LANE_W  = 2 + 2*LOG_N + DATA_W,
  localparam int DST_LSB = DATA_W,
  localparam int SRC_LSB = DATA_W + LOG_N,
  localparam int VLD_BIT = DATA_W + 2*LOG_N,
  localparam int BC_BIT  = VLD_BIT + 1
) (
  input  logic [LANE_W-1:0] up_i,
  input  logic [LANE_W-1:0] lo_i,
  output logic [LANE_W-1:0] up_o,
  output logic [LANE_W-1:0] lo_o,
  output logic [1:0]        mode_o,
  output logic              blk_o,
  output logic [LOG_N-1:0]  blk_src_o
);
  logic     uv, lv, ub, lb, ut, lt;
  sw_mode_e mode_d;

  assign uv = up_i[VLD_BIT];
  assign lv = lo_i[VLD_BIT];
  assign ub = up_i[BC_BIT];
  assign lb = lo_i[BC_BIT];
  assign ut = up_i[DST_LSB + TAG_BIT];
  assign lt = lo_i[DST_LSB + TAG_BIT];

  always_comb begin
    up_o   = '0;
    lo_o   = '0;
    mode_d = MODE_STRAIGHT;
    blk_o  = 1'b0;
    if (uv && ub) begin
      mode_d = MODE_UP_BC;
      up_o   = up_i;
      lo_o   = up_i;
      blk_o  = lv;
    end else if (lv && lb && !uv) begin
      mode_d = MODE_LO_BC;
      up_o   = lo_i;
      lo_o   = lo_i;
    end else if (uv) begin
      if (!ut) begin
        mode_d = MODE_STRAIGHT;
        up_o   = up_i;
        if (lv) begin
          if (!lt) blk_o = 1'b1;
          else     lo_o  = lo_i;
        end
      end else begin
        mode_d = MODE_CROSS;
        lo_o   = up_i;
        if (lv) begin
          if (lt) blk_o = 1'b1;
          else    up_o  = lo_i;
        end
      end
    end else if (lv) begin
      if (lt) begin
        mode_d = MODE_STRAIGHT;
        lo_o   = lo_i;
      end else begin
        mode_d = MODE_CROSS;
        up_o   = lo_i;
      end
    end
  end

  assign mode_o    = mode_d;
  assign blk_src_o = lo_i[SRC_LSB +: LOG_N];

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 8,
  parameter int STAGE   = 0,
  localparam int LOG_N  = $clog2(N_PORTS),
  localparam int LANE_W = 2 + 2*LOG_N + DATA_W,
  localparam int N_SW   = N_PORTS / 2
) (
  input  logic [N_PORTS*LANE_W-1:0] lanes_i,
  output logic [N_PORTS*LANE_W-1:0] lanes_o,
  output logic [2*N_SW-1:0]         mode_o,
  output logic [N_PORTS-1:0]        blk_o
);
  logic [N_PORTS*LANE_W-1:0] shuf;
  logic [N_SW-1:0]           sw_blk;
  logic [LOG_N-1:0]          sw_src [N_SW];

  omega_shuffle #(.N_PORTS(N_PORTS), .LANE_W(LANE_W)) u_shuf (
    .lanes_i (lanes_i),
    .lanes_o (shuf)
  );

  for (genvar m = 0; m < N_SW; m++) begin : g_sw
    omega_switch #(
      .LOG_N   (LOG_N),
      .DATA_W  (DATA_W),
      .TAG_BIT (LOG_N - 1 - STAGE)
    ) u_sw (
      .up_i      (shuf[(2*m)*LANE_W +: LANE_W]),
      .lo_i      (shuf[(2*m+1)*LANE_W +: LANE_W]),
      .up_o      (lanes_o[(2*m)*LANE_W +: LANE_W]),
      .lo_o      (lanes_o[(2*m+1)*LANE_W +: LANE_W]),
      .mode_o    (mode_o[2*m +: 2]),
      .blk_o     (sw_blk[m]),
      .blk_src_o (sw_src[m])
    );
  end

  always_comb begin
    blk_o = '0;
    for (int m = 0; m < N_SW; m++) begin
      if (sw_blk[m]) blk_o[sw_src[m]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net
  import omega_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 8,
  localparam int LOG_N  = $clog2(N_PORTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PORTS-1:0]        in_valid_i,
  input  logic [N_PORTS-1:0]        in_bcast_i,
  input  logic [N_PORTS*LOG_N-1:0]  in_dst_i,
  input  logic [N_PORTS*DATA_W-1:0] in_data_i,
  output logic [N_PORTS-1:0]        out_valid_o,
  output logic [N_PORTS*DATA_W-1:0] out_data_o,
  output logic [N_PORTS*LOG_N-1:0]  out_src_o,
  output logic [N_PORTS-1:0]        blocked_o,
  output logic [LOG_N*N_PORTS-1:0]  mode_o
);
  localparam int LANE_W  = 2 + 2*LOG_N + DATA_W;
  localparam int DST_LSB = DATA_W;
  localparam int SRC_LSB = DATA_W + LOG_N;
  localparam int VLD_BIT = DATA_W + 2*LOG_N;
  localparam int BC_BIT  = VLD_BIT + 1;

  logic [N_PORTS*LANE_W-1:0] lane_bus  [LOG_N+1];
  logic [N_PORTS-1:0]        blk_stage [LOG_N];
  logic [LOG_N*N_PORTS-1:0]  mode_d;
  logic [N_PORTS-1:0]        blk_d;

  logic [N_PORTS-1:0]        fin_valid, fin_bc;
  logic [LOG_N-1:0]          fin_dst [N_PORTS];
  logic [N_PORTS*LOG_N-1:0]  fin_src;
  logic [N_PORTS*DATA_W-1:0] fin_data;

  logic [N_PORTS-1:0]        out_valid_q, blk_q;
  logic [N_PORTS*DATA_W-1:0] out_data_q;
  logic [N_PORTS*LOG_N-1:0]  out_src_q;
  logic [LOG_N*N_PORTS-1:0]  mode_q;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    assign lane_bus[0][i*LANE_W +: LANE_W] = {
      in_bcast_i[i], in_valid_i[i], LOG_N'(i),
      in_dst_i[i*LOG_N +: LOG_N], in_data_i[i*DATA_W +: DATA_W]
    };
  end

  for (genvar s = 0; s < LOG_N; s++) begin : g_stage
    omega_stage #(
      .N_PORTS (N_PORTS),
      .DATA_W  (DATA_W),
      .STAGE   (s)
    ) u_stage (
      .lanes_i (lane_bus[s]),
      .lanes_o (lane_bus[s+1]),
      .mode_o  (mode_d[s*N_PORTS +: N_PORTS]),
      .blk_o   (blk_stage[s])
    );
  end

  always_comb begin
    blk_d = '0;
    for (int s = 0; s < LOG_N; s++) blk_d = blk_d | blk_stage[s];
  end

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out
    localparam int B = j*LANE_W;
    assign fin_valid[j] = lane_bus[LOG_N][B + VLD_BIT];
    assign fin_bc[j]    = lane_bus[LOG_N][B + BC_BIT];
    assign fin_dst[j]   = lane_bus[LOG_N][B + DST_LSB +: LOG_N];
    assign fin_src[j*LOG_N +: LOG_N]   = lane_bus[LOG_N][B + SRC_LSB +: LOG_N];
    assign fin_data[j*DATA_W +: DATA_W] = lane_bus[LOG_N][B +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= '0;
      out_data_q  <= '0;
      out_src_q   <= '0;
      blk_q       <= '0;
      mode_q      <= '0;
    end else begin
      out_valid_q <= fin_valid;
      out_data_q  <= fin_data;
      out_src_q   <= fin_src;
      blk_q       <= blk_d;
      mode_q      <= mode_d;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign out_src_o   = out_src_q;
  assign blocked_o   = blk_q;
  assign mode_o      = mode_q;

  // warm-up flag: history checks start one clock after reset
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar j = 0; j < N_PORTS; j++) begin : g_chk_port
    a_r2_unicast_lands_on_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fin_valid[j] && !fin_bc[j]) |-> (fin_dst[j] == LOG_N'(j)));
    a_r2_src_was_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && out_valid_q[j]) |->
        ((($past(in_valid_i) >> out_src_q[j*LOG_N +: LOG_N]) & N_PORTS'(1)) != '0));
    a_r8_blocked_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && blk_q[j]) |-> $past(in_valid_i[j]));
  end

  for (genvar k = 0; k < LOG_N*N_PORTS/2; k++) begin : g_chk_sw
    a_r4_bc_mode_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && mode_q[2*k+1]) |-> $past(|(in_valid_i & in_bcast_i)));
  end

  a_r5_msgs_conserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past((in_valid_i & in_bcast_i) == '0)) |->
      ($countones(out_valid_q) + $countones(blk_q) == $countones($past(in_valid_i))));

  a_r6_lone_bcast_floods: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past($countones(in_valid_i) == 1) && $past((in_valid_i & ~in_bcast_i) == '0))
      |-> (&out_valid_q));

endmodule

// File: tb/omega_net_bench.sv
`timescale 1ns/1ps
module omega_net_bench;
  localparam int N  = 8;
  localparam int LG = 3;
  localparam int DW = 8;
  localparam int NSW = N/2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    in_valid, in_bcast;
  logic [N*LG-1:0] in_dst;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    out_valid, blocked;
  logic [N*DW-1:0] out_data;
  logic [N*LG-1:0] out_src;
  logic [LG*N-1:0] mode;

  always #10 clk = ~clk;

  omega_net #(.N_PORTS(N), .DATA_W(DW)) u_omega_net (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_bcast_i(in_bcast), .in_dst_i(in_dst), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_src_o(out_src),
    .blocked_o(blocked), .mode_o(mode)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int sv[N], sb[N], sd[N], sdat[N];
  int cv[N], cb[N], cd[N], cs[N], cdat[N];
  int tv[N], tb[N], td[N], ts[N], tdat[N];
  logic [N-1:0]    e_valid, e_blk;
  logic [N*DW-1:0] e_data;
  logic [N*LG-1:0] e_src;
  logic [LG*N-1:0] e_mode;

  function automatic int rotl(int i);
    return ((i << 1) | (i >> (LG-1))) & (N-1);
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < N; i++) begin sv[i]=0; sb[i]=0; sd[i]=0; sdat[i]=0; end
  endtask

  task automatic mv(int from, int to);
    cv[to]=tv[from]; cb[to]=tb[from]; cd[to]=td[from]; cs[to]=ts[from]; cdat[to]=tdat[from];
  endtask

  // reference network built from R3..R7
  task automatic model();
    e_blk = '0; e_mode = '0;
    for (int i = 0; i < N; i++) begin
      cv[i]=sv[i]; cb[i]=sb[i]; cd[i]=sd[i]; cs[i]=i; cdat[i]=sdat[i];
    end
    for (int st = 0; st < LG; st++) begin
      int bitp;
      bitp = LG-1-st;
      for (int i = 0; i < N; i++) begin
        tv[rotl(i)]=cv[i]; tb[rotl(i)]=cb[i]; td[rotl(i)]=cd[i];
        ts[rotl(i)]=cs[i]; tdat[rotl(i)]=cdat[i];
      end
      for (int i = 0; i < N; i++) begin cv[i]=0; cb[i]=0; cd[i]=0; cs[i]=0; cdat[i]=0; end
      for (int m = 0; m < NSW; m++) begin
        int u, l, md, ut, lt;
        u = 2*m; l = 2*m+1; md = 0;
        ut = (td[u] >> bitp) & 1; lt = (td[l] >> bitp) & 1;
        if (tv[u]!=0 && tb[u]!=0) begin
          md = 2; mv(u,u); mv(u,l);
          if (tv[l]!=0) e_blk[ts[l]] = 1'b1;
        end else if (tv[l]!=0 && tb[l]!=0 && tv[u]==0) begin
          md = 3; mv(l,u); mv(l,l);
        end else if (tv[u]!=0) begin
          if (ut==0) begin
            md = 0; mv(u,u);
            if (tv[l]!=0) begin if (lt==0) e_blk[ts[l]]=1'b1; else mv(l,l); end
          end else begin
            md = 1; mv(u,l);
            if (tv[l]!=0) begin if (lt==1) e_blk[ts[l]]=1'b1; else mv(l,u); end
          end
        end else if (tv[l]!=0) begin
          if (lt==1) begin md = 0; mv(l,l); end
          else begin md = 1; mv(l,u); end
        end
        e_mode[2*(st*NSW+m) +: 2] = 2'(md);
      end
    end
    for (int j = 0; j < N; j++) begin
      e_valid[j] = (cv[j] != 0);
      e_data[j*DW +: DW] = DW'(cdat[j]);
      e_src[j*LG +: LG]  = LG'(cs[j]);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      in_valid[i] = (sv[i] != 0);
      in_bcast[i] = (sb[i] != 0);
      in_dst[i*LG +: LG]  = LG'(sd[i]);
      in_data[i*DW +: DW] = DW'(sdat[i]);
    end
  endtask

  task automatic cmp_all(string tag);
    chk({tag, " R2 out_valid"}, 128'(out_valid), 128'(e_valid));
    chk({tag, " R2 out_data"},  128'(out_data),  128'(e_data));
    chk({tag, " R2 out_src"},   128'(out_src),   128'(e_src));
    chk({tag, " R5 blocked"},   128'(blocked),   128'(e_blk));
    chk({tag, " R4 mode"},      128'(mode),      128'(e_mode));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(string tag);
    drive(); model();
    @(negedge clk);
    cmp_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd51966));
    clear_stim(); drive();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", 128'(out_valid), 128'(0));
    chk("R1 reset blocked", 128'(blocked), 128'(0));
    chk("R1 reset mode", 128'(mode), 128'(0));
    rst_n = 1'b1;
    step("R1 idle");

    // R1 one-cycle latency
    clear_stim(); sv[5]=1; sd[5]=2; sdat[5]=8'h5A;
    drive(); model();
    #5;
    chk("R1 not yet", 128'(out_valid), 128'(0));
    @(negedge clk);
    cmp_all("R1 latency");
    chk("R2 single at dst2", 128'(out_data[2*DW +: DW]), 128'(8'h5A));
    chk("R2 single src5", 128'(out_src[2*LG +: LG]), 128'(5));

    // R2 identity permutation
    clear_stim();
    for (int i = 0; i < N; i++) begin sv[i]=1; sd[i]=i; sdat[i]=8'h10+i; end
    step("R3 identity");
    chk("R2 identity all", 128'(out_valid), 128'({N{1'b1}}));
    chk("R5 identity none blocked", 128'(blocked), 128'(0));

    // R5 conflict: 2->7 upper, 6->4 lower, both need lower link of stage0 sw2
    clear_stim(); sv[2]=1; sd[2]=7; sdat[2]=8'hA2; sv[6]=1; sd[6]=4; sdat[6]=8'hA6;
    step("R5 conflict");
    chk("R5 lower blocked", 128'(blocked), 128'(8'b0100_0000));
    chk("R5 upper delivered", 128'(out_valid), 128'(8'b1000_0000));
    chk("R5 src at 7", 128'(out_src[7*LG +: LG]), 128'(2));

    // R5 lone broadcast floods
    clear_stim(); sv[3]=1; sb[3]=1; sd[3]=0; sdat[3]=8'hC3;
    step("R6 flood");
    chk("R6 flood valid", 128'(out_valid), 128'({N{1'b1}}));
    chk("R6 flood src", 128'(out_src), 128'({N{3'd3}}));

    // R6 upper broadcast blocks lower: src0 upper, src4 lower at stage0 sw0
    clear_stim(); sv[0]=1; sb[0]=1; sdat[0]=8'hB0; sv[4]=1; sd[4]=3; sdat[4]=8'hB4;
    step("R6 up bc");
    chk("R6 mode 10", 128'(mode[1:0]), 128'(2'b10));
    chk("R6 lower blocked", 128'(blocked), 128'(8'b0001_0000));

    // R7 lower broadcast refused while upper busy
    clear_stim(); sv[0]=1; sd[0]=0; sdat[0]=8'hD0; sv[4]=1; sb[4]=1; sd[4]=5; sdat[4]=8'hD4;
    step("R7 lo bc");
    chk("R7 mode straight", 128'(mode[1:0]), 128'(2'b00));
    chk("R7 valid pattern", 128'(out_valid), 128'(8'b1111_0001));
    chk("R7 no block", 128'(blocked), 128'(0));

    // R7 lower broadcast granted with upper idle
    clear_stim(); sv[4]=1; sb[4]=1; sd[4]=1; sdat[4]=8'hE4;
    step("R7 lo bc idle");
    chk("R7 mode 11", 128'(mode[1:0]), 128'(2'b11));

    // R8 idle inputs with stray fields
    clear_stim();
    for (int i = 0; i < N; i++) begin sb[i]=i%2; sd[i]=N-1-i; sdat[i]=8'hF0+i; end
    step("R8 idle");
    chk("R8 no output", 128'(out_valid), 128'(0));
    chk("R8 no block", 128'(blocked), 128'(0));

    // random sparse traffic with rare broadcast
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < N; i++) begin
        sv[i] = (($urandom % 4) != 0) ? 1 : 0;
        sb[i] = (($urandom % 16) == 0) ? 1 : 0;
        sd[i] = $urandom % N;
        sdat[i] = $urandom % 256;
      end
      step("rand");
    end

    // random full permutations
    for (int t = 0; t < 200; t++) begin
      clear_stim();
      for (int i = 0; i < N; i++) begin sv[i]=1; sd[i]=i; sdat[i]=$urandom % 256; end
      for (int i = N-1; i > 0; i--) begin
        int r, tmp;
        r = $urandom % (i+1); tmp = sd[i]; sd[i] = sd[r]; sd[r] = tmp;
      end
      step("perm");
    end

    // R1 asynchronous reset mid-traffic
    clear_stim();
    for (int i = 0; i < N; i++) begin sv[i]=1; sd[i]=i; sdat[i]=i; end
    step("R1 pre-reset");
    rst_n = 1'b0;
    #2;
    chk("R1 async valid", 128'(out_valid), 128'(0));
    chk("R1 async mode", 128'(mode), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 post-reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule